// File: doc/BRIEF.md
# Split Page Translation Cache

This block remembers recent linear-to-physical page translations for a 32-bit paged memory system with 4 KiB pages. It keeps two separate direct-mapped arrays: one serves data accesses and the other serves instruction fetches. A code-access flag on each request picks the array. A lookup is purely combinational. It returns a hit and the physical page base in the same cycle the linear address is presented.

A hit is granted only when three things hold together. The slot must be valid with a matching tag. The access must pass a five-input permission check. A write must also find the dirty flag already set. When any of these fails, the block reports a miss and the page walker runs again. The walker then writes the fresh translation through the fill port. Software-driven maintenance uses three controls: a full flush, a flush that spares global pages, and a single-page invalidate.

Top module: `xlt_split_cache`

## Requirements
- R1: After reset every slot in both arrays is invalid, so every lookup misses.
- R2: The slot index is linear address bits 17:12 and the stored tag is bits 31:12. A lookup whose index matches but whose bits 31:12 differ from the stored tag misses.
- R3: Permission is taken from bit n of the constant 0xD0DDD0FF. The index n is the 5-bit value {write-protect mode (bit 4), requester is user (bit 3), slot user (bit 2), slot writable (bit 1), access is a write (bit 0)}. A lookup for which that bit is 0 misses.
- R4: A write lookup hits only if the slot's dirty flag is set. A read ignores the dirty flag.
- R5: A fill writes the array chosen by `fl_code` (0 = data, 1 = code). It stores the tag, the writable, user, dirty and global flags, and the page base, and marks the slot valid. The other array is left unchanged.
- R6: A full flush invalidates every slot of both arrays. It takes precedence over a fill issued in the same cycle.
- R7: A non-global flush invalidates, in both arrays, every slot whose global flag is clear. Slots marked global stay valid.
- R8: A single-page invalidate examines the addressed slot in both arrays. It invalidates a slot only when that slot is valid and its tag equals bits 31:12 of `fx_laddr`.
- R9: A lookup returns the contents held before the current clock edge. A fill issued in the same cycle becomes visible one cycle later. A fill takes precedence over a non-global flush or page invalidate on the same slot in the same cycle.
- R10: On a hit, `lk_pbase` equals the stored page base. On a miss it is zero.
- R11: With parameter GLOBAL_EN = 0 the global flag is disregarded, and a non-global flush invalidates every slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_laddr | input | 32 | Lookup linear address |
| lk_write | input | 1 | Lookup is a write access |
| lk_user | input | 1 | Requester runs at user privilege |
| lk_code | input | 1 | Lookup is an instruction fetch (selects code array) |
| lk_wp | input | 1 | Supervisor write-protect mode enabled |
| lk_hit | output | 1 | Lookup hit |
| lk_pbase | output | 20 | Physical page base on hit, zero on miss |
| fl_en | input | 1 | Fill strobe from the page walker |
| fl_laddr | input | 32 | Linear address being filled |
| fl_code | input | 1 | Fill targets the code array |
| fl_wr | input | 1 | Combined writable right |
| fl_usr | input | 1 | Combined user right |
| fl_dirty | input | 1 | Dirty flag of the table entry |
| fl_glob | input | 1 | Global flag of the table entry |
| fl_pbase | input | 20 | Physical page base to store |
| fx_all | input | 1 | Full flush of both arrays |
| fx_local | input | 1 | Flush of non-global slots |
| fx_page | input | 1 | Single-page invalidate strobe |
| fx_laddr | input | 32 | Linear address of the page to invalidate |

## Verification
A corrupted slot shows up at `lk_hit` and `lk_pbase` in the very first cycle a lookup reaches that index. Such a slot may hold a stale valid bit, a wrong tag, a lost flag or a swapped array. A bench reference model of both arrays predicts the result of every cycle's lookup, so a divergence is caught on the next access to the damaged slot. The random phase uses a small pool of tags that alias on the same indices, which keeps those accesses frequent. Flags influence the result only through the permission and dirty rules. For that reason a directed sweep crosses every slot flag pair with every requester combination, so that a flag error cannot hide behind an always-permitted access.

// File: rtl/xlt_pkg.sv
`timescale 1ns/1ps
package xlt_pkg;

   // permission bit pattern: bit n allows access for index n
   localparam logic [31:0] XLT_PERM_TABLE = 32'hD0DDD0FF;

   localparam int XLT_NBANK = 2;

   typedef enum logic {
      XLT_BANK_DATA = 1'b0,
      XLT_BANK_CODE = 1'b1
   } xlt_bank_e;

   // ordering matters: it forms the permission index, msb first
   typedef struct packed {
      logic wp_mode;
      logic req_user;
      logic ent_user;
      logic ent_wr;
      logic is_write;
   } xlt_perm_idx_t;

endpackage

// File: rtl/xlt_perm.sv
`timescale 1ns/1ps
module xlt_perm
   import xlt_pkg::*;
#(
   parameter logic [31:0] TABLE = XLT_PERM_TABLE
) (
   input  xlt_perm_idx_t idx,
   output logic          allow
);
   localparam int IDX_W = $bits(xlt_perm_idx_t);

   generate
      if (IDX_W != 5) begin : g_bad_idx
         $error("permission index must be five bits");
      end
   endgenerate

   logic [IDX_W-1:0] flat;

   always_comb begin
      flat  = idx;
      allow = TABLE[flat];
   end
endmodule

// File: rtl/xlt_bank.sv
`timescale 1ns/1ps
module xlt_bank #(
   parameter int TAG_W     = 20,
   parameter int IDX_W     = 6,
   parameter int PB_W      = 20,
   parameter bit GLOBAL_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   // read side
   input  logic [IDX_W-1:0] rd_idx,
   output logic             rd_valid,
   output logic [TAG_W-1:0] rd_tag,
   output logic             rd_wr,
   output logic             rd_usr,
   output logic             rd_dirty,
   output logic [PB_W-1:0]  rd_pbase,
   // write side
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0] wr_tag,
   input  logic             wr_wr,
   input  logic             wr_usr,
   input  logic             wr_dirty,
   input  logic             wr_glob,
   input  logic [PB_W-1:0]  wr_pbase,
   // maintenance
   input  logic             clr_all,
   input  logic             clr_local,
   input  logic             inv_en,
   input  logic [IDX_W-1:0] inv_idx,
   input  logic [TAG_W-1:0] inv_tag
);
   localparam int DEPTH = 1 << IDX_W;

   generate
      if (IDX_W < 1 || IDX_W > 10) begin : g_bad_depth
         $error("bank index width out of range");
      end
   endgenerate

   logic [DEPTH-1:0] val_q, val_d;
   logic [DEPTH-1:0] wrf_q, usrf_q, drt_q;
   logic [DEPTH-1:0] glob_eff;
   logic [TAG_W-1:0] tag_q [DEPTH];
   logic [PB_W-1:0]  pb_q  [DEPTH];

   logic take_fill;
   assign take_fill = wr_en && !clr_all;

   // global flag storage is present only when honoured
   generate
      if (GLOBAL_EN) begin : g_glob
         logic [DEPTH-1:0] glob_q;
         always_ff @(posedge clk) begin
            if (take_fill) glob_q[wr_idx] <= wr_glob;
         end
         assign glob_eff = glob_q;
      end else begin : g_noglob
         logic unused_glob;
         assign unused_glob = wr_glob;
         assign glob_eff    = '0;
      end
   endgenerate

   // valid bits: full flush > fill > local flush > page invalidate
   always_comb begin
      for (int e = 0; e < DEPTH; e++) begin
         val_d[e] = val_q[e];
         if (clr_all) begin
            val_d[e] = 1'b0;
         end else if (wr_en && wr_idx == IDX_W'(e)) begin
            val_d[e] = 1'b1;
         end else if (clr_local && !glob_eff[e]) begin
            val_d[e] = 1'b0;
         end else if (inv_en && inv_idx == IDX_W'(e) && tag_q[e] == inv_tag) begin
            val_d[e] = 1'b0;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) val_q <= '0;
      else        val_q <= val_d;
   end

   // payload has no reset: it is qualified by the valid bit
   always_ff @(posedge clk) begin
      if (take_fill) begin
         tag_q[wr_idx]  <= wr_tag;
         pb_q[wr_idx]   <= wr_pbase;
         wrf_q[wr_idx]  <= wr_wr;
         usrf_q[wr_idx] <= wr_usr;
         drt_q[wr_idx]  <= wr_dirty;
      end
   end

   always_comb begin
      rd_valid = val_q[rd_idx];
      rd_tag   = tag_q[rd_idx];
      rd_wr    = wrf_q[rd_idx];
      rd_usr   = usrf_q[rd_idx];
      rd_dirty = drt_q[rd_idx];
      rd_pbase = pb_q[rd_idx];
   end
endmodule

// File: rtl/xlt_split_cache.sv
`timescale 1ns/1ps
module xlt_split_cache
   import xlt_pkg::*;
#(
   parameter int LA_W       = 32,
   parameter int PA_W       = 32,
   parameter int PAGE_SHIFT = 12,
   parameter int IDX_W      = 6,
   parameter bit GLOBAL_EN  = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [31:0]           lk_laddr,
   input  logic                  lk_write,
   input  logic                  lk_user,
   input  logic                  lk_code,
   input  logic                  lk_wp,
   output logic                  lk_hit,
   output logic [19:0]           lk_pbase,
   input  logic                  fl_en,
   input  logic [31:0]           fl_laddr,
   input  logic                  fl_code,
   input  logic                  fl_wr,
   input  logic                  fl_usr,
   input  logic                  fl_dirty,
   input  logic                  fl_glob,
   input  logic [19:0]           fl_pbase,
   input  logic                  fx_all,
   input  logic                  fx_local,
   input  logic                  fx_page,
   input  logic [31:0]           fx_laddr
);
   localparam int TAG_W = LA_W - PAGE_SHIFT;
   localparam int PB_W  = PA_W - PAGE_SHIFT;

   generate
      if (LA_W != 32 || PA_W != 32) begin : g_bad_width
         $error("port widths assume 32-bit addresses");
      end
      if (PAGE_SHIFT + IDX_W > LA_W) begin : g_bad_index
         $error("index field exceeds linear address");
      end
   endgenerate

   logic [IDX_W-1:0] lk_idx, fl_idx, fx_idx;
   logic [TAG_W-1:0] lk_tag, fl_tag, fx_tag;

   assign lk_idx = lk_laddr[PAGE_SHIFT +: IDX_W];
   assign fl_idx = fl_laddr[PAGE_SHIFT +: IDX_W];
   assign fx_idx = fx_laddr[PAGE_SHIFT +: IDX_W];
   assign lk_tag = lk_laddr[LA_W-1:PAGE_SHIFT];
   assign fl_tag = fl_laddr[LA_W-1:PAGE_SHIFT];
   assign fx_tag = fx_laddr[LA_W-1:PAGE_SHIFT];

   logic [XLT_NBANK-1:0] rd_v, rd_w, rd_u, rd_d;
   logic [TAG_W-1:0]     rd_t [XLT_NBANK];
   logic [PB_W-1:0]      rd_p [XLT_NBANK];

   generate
      for (genvar b = 0; b < XLT_NBANK; b++) begin : g_bank
         logic bank_fill;
         assign bank_fill = fl_en && (fl_code == ((b == int'(XLT_BANK_CODE)) ? 1'b1 : 1'b0));

         xlt_bank #(
            .TAG_W     (TAG_W),
            .IDX_W     (IDX_W),
            .PB_W      (PB_W),
            .GLOBAL_EN (GLOBAL_EN)
         ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_idx    (lk_idx),
            .rd_valid  (rd_v[b]),
            .rd_tag    (rd_t[b]),
            .rd_wr     (rd_w[b]),
            .rd_usr    (rd_u[b]),
            .rd_dirty  (rd_d[b]),
            .rd_pbase  (rd_p[b]),
            .wr_en     (bank_fill),
            .wr_idx    (fl_idx),
            .wr_tag    (fl_tag),
            .wr_wr     (fl_wr),
            .wr_usr    (fl_usr),
            .wr_dirty  (fl_dirty),
            .wr_glob   (fl_glob),
            .wr_pbase  (fl_pbase),
            .clr_all   (fx_all),
            .clr_local (fx_local),
            .inv_en    (fx_page),
            .inv_idx   (fx_idx),
            .inv_tag   (fx_tag)
         );
      end
   endgenerate

   // selected slot
   logic             sel_valid, sel_wr, sel_usr, sel_dirty;
   logic [TAG_W-1:0] sel_tag;
   logic [PB_W-1:0]  sel_pbase;

   always_comb begin
      sel_valid = rd_v[lk_code];
      sel_wr    = rd_w[lk_code];
      sel_usr   = rd_u[lk_code];
      sel_dirty = rd_d[lk_code];
      sel_tag   = rd_t[lk_code];
      sel_pbase = rd_p[lk_code];
   end

   xlt_perm_idx_t perm_idx;
   logic          perm_ok;

   assign perm_idx = '{wp_mode: lk_wp, req_user: lk_user, ent_user: sel_usr,
                       ent_wr: sel_wr, is_write: lk_write};

   xlt_perm #(.TABLE(XLT_PERM_TABLE)) u_perm (
      .idx   (perm_idx),
      .allow (perm_ok)
   );

   logic tag_eq, dirty_ok;
   assign tag_eq   = (sel_tag == lk_tag);
   assign dirty_ok = !lk_write || sel_dirty;

   assign lk_hit   = sel_valid && tag_eq && perm_ok && dirty_ok;
   assign lk_pbase = lk_hit ? sel_pbase : '0;
endmodule

// File: rtl/xlt_split_cache_chk.sv
`timescale 1ns/1ps
module xlt_split_cache_chk (
   input logic        clk,
   input logic        rst_n,
   input logic [31:0] lk_laddr,
   input logic        lk_write,
   input logic        lk_user,
   input logic        lk_code,
   input logic        lk_wp,
   input logic        lk_hit,
   input logic        fl_en,
   input logic [31:0] fl_laddr,
   input logic        fl_code,
   input logic        fx_all,
   input logic        fx_page,
   input logic [31:0] fx_laddr,
   input logic        sel_wr,
   input logic        sel_usr,
   input logic        sel_dirty
);
   // R6: nothing survives a full flush
   a_r6_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
      fx_all |=> !lk_hit);

   // R4: a write hit requires the stored dirty flag
   a_r4_write_needs_dirty: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && lk_write) |-> sel_dirty);

   // R3: user requesters hit only on user slots
   a_r3_user_slot: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && lk_user) |-> sel_usr);

   // R3: protected writes hit only on writable slots
   a_r3_write_right: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_hit && lk_write && (lk_wp || lk_user)) |-> sel_wr);

   // R8: the invalidated page misses on the next cycle when no fill intervenes
   a_r8_page_gone: assert property (@(posedge clk) disable iff (!rst_n)
      (fx_page && !fl_en) |=>
         ((lk_laddr[31:12] != $past(fx_laddr[31:12])) || !lk_hit));

   // R5: a filled page is visible next cycle to a supervisor read of the same array
   a_r5_fill_visible: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_en && !fx_all) |=>
         (!(lk_laddr[31:12] == $past(fl_laddr[31:12]) && lk_code == $past(fl_code)
            && !lk_user && !lk_write) || lk_hit));

   logic unused_chk;
   assign unused_chk = lk_wp ^ fl_code;
endmodule

bind xlt_split_cache xlt_split_cache_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .lk_laddr  (lk_laddr),
   .lk_write  (lk_write),
   .lk_user   (lk_user),
   .lk_code   (lk_code),
   .lk_wp     (lk_wp),
   .lk_hit    (lk_hit),
   .fl_en     (fl_en),
   .fl_laddr  (fl_laddr),
   .fl_code   (fl_code),
   .fx_all    (fx_all),
   .fx_page   (fx_page),
   .fx_laddr  (fx_laddr),
   .sel_wr    (sel_wr),
   .sel_usr   (sel_usr),
   .sel_dirty (sel_dirty)
);

// File: tb/sim_xlt_split_cache.sv
`timescale 1ns/1ps
module sim_xlt_split_cache;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] lk_laddr = '0;
   logic        lk_write = 0, lk_user = 0, lk_code = 0, lk_wp = 0;
   logic        fl_en = 0, fl_code = 0, fl_wr = 0, fl_usr = 0, fl_dirty = 0, fl_glob = 0;
   logic [31:0] fl_laddr = '0;
   logic [19:0] fl_pbase = '0;
   logic        fx_all = 0, fx_local = 0, fx_page = 0;
   logic [31:0] fx_laddr = '0;
   logic        hit0, hit1;
   logic [19:0] pb0, pb1;

   int total = 0;
   int fails = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   xlt_split_cache #(.GLOBAL_EN(1'b1)) u0 (
      .clk(clk), .rst_n(rst_n), .lk_laddr(lk_laddr), .lk_write(lk_write),
      .lk_user(lk_user), .lk_code(lk_code), .lk_wp(lk_wp), .lk_hit(hit0),
      .lk_pbase(pb0), .fl_en(fl_en), .fl_laddr(fl_laddr), .fl_code(fl_code),
      .fl_wr(fl_wr), .fl_usr(fl_usr), .fl_dirty(fl_dirty), .fl_glob(fl_glob),
      .fl_pbase(fl_pbase), .fx_all(fx_all), .fx_local(fx_local),
      .fx_page(fx_page), .fx_laddr(fx_laddr));

   // second copy with the global flag disregarded (R11)
   xlt_split_cache #(.GLOBAL_EN(1'b0)) u1 (
      .clk(clk), .rst_n(rst_n), .lk_laddr(lk_laddr), .lk_write(lk_write),
      .lk_user(lk_user), .lk_code(lk_code), .lk_wp(lk_wp), .lk_hit(hit1),
      .lk_pbase(pb1), .fl_en(fl_en), .fl_laddr(fl_laddr), .fl_code(fl_code),
      .fl_wr(fl_wr), .fl_usr(fl_usr), .fl_dirty(fl_dirty), .fl_glob(fl_glob),
      .fl_pbase(fl_pbase), .fx_all(fx_all), .fx_local(fx_local),
      .fx_page(fx_page), .fx_laddr(fx_laddr));

   // reference model [instance][array][slot]
   bit          mv [2][2][64];
   bit          mw [2][2][64];
   bit          mu [2][2][64];
   bit          md [2][2][64];
   bit          mg [2][2][64];
   logic [19:0] mt [2][2][64];
   logic [19:0] mp [2][2][64];

   localparam logic [31:0] ALLOW = 32'hD0DDD0FF;

   function automatic bit perm_ok(bit wp, bit cu, bit eu, bit ew, bit w);
      return ALLOW[{wp, cu, eu, ew, w}];
   endfunction

   function automatic bit exp_hit(int i);
      int b = int'(lk_code);
      int e = int'(lk_laddr[17:12]);
      return mv[i][b][e] && mt[i][b][e] == lk_laddr[31:12]
             && perm_ok(lk_wp, lk_user, mu[i][b][e], mw[i][b][e], lk_write)
             && (!lk_write || md[i][b][e]);
   endfunction

   task automatic check(bit ok, string req, logic [20:0] act, logic [20:0] exp);
      total++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic model_update();
      for (int i = 0; i < 2; i++)
         for (int b = 0; b < 2; b++)
            for (int e = 0; e < 64; e++) begin
               if (fx_all) mv[i][b][e] = 0;
               else if (fl_en && b == int'(fl_code) && e == int'(fl_laddr[17:12])) begin
                  mv[i][b][e] = 1; mt[i][b][e] = fl_laddr[31:12];
                  mw[i][b][e] = fl_wr; mu[i][b][e] = fl_usr;
                  md[i][b][e] = fl_dirty; mg[i][b][e] = fl_glob;
                  mp[i][b][e] = fl_pbase;
               end else if (fx_local && !(i == 0 && mg[i][b][e])) mv[i][b][e] = 0;
               else if (fx_page && e == int'(fx_laddr[17:12]) && mv[i][b][e]
                        && mt[i][b][e] == fx_laddr[31:12]) mv[i][b][e] = 0;
            end
   endtask

   // inputs were driven at a falling edge; compare, update model, advance
   task automatic step(string req);
      bit h0, h1;
      #1;
      h0 = exp_hit(0);
      h1 = exp_hit(1);
      check(hit0 == h0 && pb0 == (h0 ? mp[0][lk_code][lk_laddr[17:12]] : 20'h0),
            {req, " u0"}, {hit0, pb0}, {h0, h0 ? mp[0][lk_code][lk_laddr[17:12]] : 20'h0});
      check(hit1 == h1 && pb1 == (h1 ? mp[1][lk_code][lk_laddr[17:12]] : 20'h0),
            {req, " u1"}, {hit1, pb1}, {h1, h1 ? mp[1][lk_code][lk_laddr[17:12]] : 20'h0});
      model_update();
      @(negedge clk);
   endtask

   task automatic quiet();
      fl_en = 0; fx_all = 0; fx_local = 0; fx_page = 0;
   endtask

   task automatic fill(logic [31:0] a, bit c, bit w, bit u, bit d, bit g, logic [19:0] p);
      fl_en = 1; fl_laddr = a; fl_code = c; fl_wr = w; fl_usr = u;
      fl_dirty = d; fl_glob = g; fl_pbase = p;
   endtask

   task automatic look(logic [31:0] a, bit c, bit w, bit u, bit wp);
      lk_laddr = a; lk_code = c; lk_write = w; lk_user = u; lk_wp = wp;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; total++;
         $display("FAIL watchdog expired");
         $display("  %0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      for (int i = 0; i < 2; i++)
         for (int b = 0; b < 2; b++)
            for (int e = 0; e < 64; e++) begin
               mv[i][b][e] = 0; mw[i][b][e] = 0; mu[i][b][e] = 0;
               md[i][b][e] = 0; mg[i][b][e] = 0; mt[i][b][e] = '0; mp[i][b][e] = '0;
            end
      void'($urandom(32'd2024));
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R1: empty after reset
      look(32'h0000_0000, 0, 0, 0, 0); step("R1 reset data");
      look(32'h0000_3000, 1, 0, 0, 0); step("R1 reset code");

      // R9: fill and lookup in the same cycle sees the old contents
      fill(32'h1234_5678, 0, 1, 1, 1, 0, 20'hABCDE);
      look(32'h1234_5000, 0, 0, 0, 0); step("R9 same-cycle fill");
      quiet();
      look(32'h1234_5000, 0, 0, 0, 0); step("R5 R10 data hit");
      look(32'h1234_5000, 1, 0, 0, 0); step("R5 code array untouched");
      look(32'h5674_5000, 0, 0, 0, 0); step("R2 alias tag miss");

      // R3: sweep slot rights against requester combinations
      for (int r = 0; r < 4; r++) begin
         fill(32'h0004_0000 | (32'(r) << 12), 0, r[0], r[1], 1, 0, 20'(r + 16));
         step("R3 setup");
         quiet();
         for (int q = 0; q < 8; q++) begin
            look(32'h0004_0000 | (32'(r) << 12), 0, q[0], q[1], q[2]);
            step("R3 permission sweep");
         end
      end

      // R4: writable slot without dirty
      fill(32'h0009_1000, 0, 1, 1, 0, 0, 20'h00777); step("R4 setup");
      quiet();
      look(32'h0009_1000, 0, 0, 1, 0); step("R4 read ignores dirty");
      look(32'h0009_1000, 0, 1, 1, 0); step("R4 write needs dirty");

      // R7 / R11: global survives on u0 only
      fill(32'h0002_2000, 0, 1, 1, 1, 1, 20'h00222); step("R7 setup");
      fill(32'h0002_3000, 1, 1, 1, 1, 0, 20'h00233); step("R7 setup");
      quiet(); fx_local = 1; step("R7 local flush");
      quiet();
      look(32'h0002_2000, 0, 0, 0, 0); step("R7 R11 global slot");
      look(32'h0002_3000, 1, 0, 0, 0); step("R7 nonglobal slot");

      // R8: page invalidate in both arrays, tag checked
      fill(32'h0003_5000, 0, 1, 1, 1, 0, 20'h00350); step("R8 setup");
      fill(32'h0003_5000, 1, 1, 1, 1, 0, 20'h00351); step("R8 setup");
      quiet(); fx_page = 1; fx_laddr = 32'hFFF3_5000; step("R8 wrong tag");
      quiet();
      look(32'h0003_5000, 0, 0, 0, 0); step("R8 kept on tag mismatch");
      fx_page = 1; fx_laddr = 32'h0003_5ABC; step("R8 matching invalidate");
      quiet();
      look(32'h0003_5000, 0, 0, 0, 0); step("R8 data cleared");
      look(32'h0003_5000, 1, 0, 0, 0); step("R8 code cleared");

      // R9: fill beats page invalidate on same slot
      fill(32'h0003_6000, 1, 0, 0, 1, 0, 20'h00360); fx_page = 1; fx_laddr = 32'h0003_6000;
      step("R9 fill vs invalidate");
      quiet(); look(32'h0003_6000, 1, 0, 0, 0); step("R9 fill survives");

      // R6: full flush beats fill
      fill(32'h0007_7000, 0, 1, 1, 1, 1, 20'h00770); fx_all = 1; step("R6 flush with fill");
      quiet();
      look(32'h0007_7000, 0, 0, 0, 0); step("R6 fill dropped");
      look(32'h0002_2000, 0, 0, 0, 0); step("R6 global also cleared");

      // random phase over a small aliasing tag pool
      for (int n = 0; n < 4000; n++) begin
         logic [13:0] hi;
         int sel, pick;
         sel = int'($urandom % 3);
         hi  = (sel == 0) ? 14'h0 : (sel == 1) ? 14'h1 : 14'h3A5;
         lk_laddr = {hi, 6'($urandom % 4), 12'($urandom)};
         lk_code = 1'($urandom); lk_write = 1'($urandom);
         lk_user = 1'($urandom); lk_wp = 1'($urandom);
         quiet();
         pick = int'($urandom % 100);
         if (pick < 40) begin
            sel = int'($urandom % 3);
            hi  = (sel == 0) ? 14'h0 : (sel == 1) ? 14'h1 : 14'h3A5;
            fill({hi, 6'($urandom % 4), 12'h0}, 1'($urandom), 1'($urandom),
                 1'($urandom), 1'($urandom), 1'($urandom), 20'($urandom));
         end
         if (pick >= 40 && pick < 42) fx_all = 1;
         if (pick >= 42 && pick < 46) fx_local = 1;
         if (pick >= 46 && pick < 56) begin
            fx_page = 1;
            sel = int'($urandom % 3);
            hi  = (sel == 0) ? 14'h0 : (sel == 1) ? 14'h1 : 14'h3A5;
            fx_laddr = {hi, 6'($urandom % 4), 12'($urandom)};
         end
         step("R2 R3 R4 R5 R10 random");
      end

      done = 1;
      $display("  %0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule